// File: doc/BRIEF.md
# Pipelined Bus Request Issuer

This block is the card-side end of a pipelined request channel to host memory. Local logic presents one request at a time: a command, a 64-bit byte address, a 3-bit length code, a keep-state hint and, for writes, a flag that the write data is already staged. The issuer turns each accepted request into one or two strobed cycles on a 32-bit address/command bus. It never waits for the host to acknowledge a request. The number of requests in flight is limited only by a credit count compared against a programmable depth.

The issuer keeps a stored command and a stored upper address word. A request whose command and upper word match that stored state goes out as one short cycle. On a mismatch, a request with the keep-state hint first sends a setup cycle, which rewrites the stored state and queues nothing, and then the short cycle. A request without the hint is sent self-contained instead: one full cycle when the upper word is zero, or a dual address pair when it is not. Fence and flush are sent as full cycles with a zero address. A fence stops all further issue until every earlier request has retired. A flush takes a credit and is retired like a read. Retirement pulses from the host (read response delivered, write data pulled) return credits.

Top module: `pipe_req_issuer`

## Requirements
- R1: After reset the strobe is low, the outstanding count is 0, the underflow flag is 0, and a read request with a zero upper word is ready at once.
- R2: Each accepted request drives the strobe high in the next cycle, and requests with a zero upper word held valid are accepted on consecutive cycles with no acknowledgement, one strobed cycle each.
- R3: A request that takes a credit (codes 0-3 and 5) is ready only while outstanding < limit. The limit is the depth input, where 0 counts as 1 and values above 256 count as 256.
- R4: Lowering the depth below the outstanding count blocks issue until the count falls below the new depth, and then issue resumes.
- R5: For a keep-state request whose command or upper word differs from the stored state, the bus carries a setup cycle (kind 1, bus = address bits 63:32) and then a short cycle (kind 0, bus = {address bits 31:3, length}), both with the request's command. One credit is taken.
- R6: A read or write whose command and upper word equal the stored state goes out as a single short cycle (kind 0), whatever the hint.
- R7: A mismatching request with a zero upper word and no hint goes out as one full cycle (kind 2, bus = {address bits 31:3, length}) and leaves the stored state unchanged.
- R8: A mismatching request with a non-zero upper word and no hint goes out as a dual address pair: kind 3 carrying the low word, then kind 4 carrying bits 63:32, with the same command.
- R9: A fence (code 4) goes out as kind 2 with a zero bus word and takes no credit. No request is ready again until the outstanding count has reached 0.
- R10: A flush (code 5) goes out as kind 2 with a zero bus word and takes one credit.
- R11: A write (code 2 or 3) is never ready while its data-staged flag is 0, and the unused codes 6 and 7 are never ready.
- R12: Each read-retire pulse and each write-retire pulse removes one credit. Both in the same cycle remove two.
- R13: A retirement beyond the outstanding count leaves the count at 0 and sets a sticky underflow flag that holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 9 | Programmed maximum outstanding requests |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Request accepted at this clock edge when valid |
| req_cmd | input | 3 | 0 read low, 1 read high, 2 write low, 3 write high, 4 fence, 5 flush |
| req_addr | input | 64 | Byte address |
| req_len | input | 3 | Length code placed in the low bits of the bus word |
| req_sticky | input | 1 | On mismatch, update stored state through a setup cycle |
| req_wdata_ok | input | 1 | Write data is already staged |
| rd_done | input | 1 | Host finished returning one read response |
| wr_done | input | 1 | Host pulled the data of one write |
| pipe_o | output | 1 | Strobe: this cycle carries a request word |
| kind_o | output | 3 | 0 short, 1 setup, 2 full, 3 dual-low, 4 dual-high |
| cmd_o | output | 3 | Command of the current cycle |
| ad_o | output | 32 | Address/command bus word |
| outstanding_o | output | 9 | Requests in flight |
| underflow_o | output | 1 | Sticky retire-underflow flag |

## Verification
The hardest state to reach from the ports is a depth lowered below a count that is already in flight. The count must first be built up with back-to-back issue under a generous depth. The depth is then cut, and single retire pulses walk the count down while readiness is probed after each step, so the cycle where issue resumes is observed exactly. Fence blocking is reached the same way, with credits held before the fence and released one at a time. The stored-state paths are reached by ordering a keep-state request before unrelated full and dual requests, and then sending a request that matches the state set first.

// File: rtl/pri_pkg.sv
package pri_pkg;

  localparam int BUS_W = 32;
  localparam int LEN_W = 3;
  localparam int CMD_W = 3;
  localparam int KIND_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_RD_LO = 3'd0,
    CMD_RD_HI = 3'd1,
    CMD_WR_LO = 3'd2,
    CMD_WR_HI = 3'd3,
    CMD_FENCE = 3'd4,
    CMD_FLUSH = 3'd5
  } cmd_e;

  typedef enum logic [KIND_W-1:0] {
    CYC_SHORT  = 3'd0,
    CYC_SETUP  = 3'd1,
    CYC_FULL   = 3'd2,
    CYC_DAC_LO = 3'd3,
    CYC_DAC_HI = 3'd4
  } cyc_e;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [CMD_W-1:0]  cmd;
    logic [BUS_W-1:0]  ad;
  } beat_t;

  function automatic logic cmd_known(input logic [CMD_W-1:0] c);
    return c <= CMD_FLUSH;
  endfunction

  function automatic logic cmd_is_write(input logic [CMD_W-1:0] c);
    return (c == CMD_WR_LO) || (c == CMD_WR_HI);
  endfunction

  function automatic logic cmd_is_mem(input logic [CMD_W-1:0] c);
    return c <= CMD_WR_HI;
  endfunction

  function automatic logic cmd_takes_credit(input logic [CMD_W-1:0] c);
    return cmd_is_mem(c) || (c == CMD_FLUSH);
  endfunction

  // Effective depth: zero behaves as one, above the ceiling behaves as the ceiling.
  function automatic int clamp_depth(input int raw, input int ceiling);
    if (raw < 1) return 1;
    if (raw > ceiling) return ceiling;
    return raw;
  endfunction

  // Saturating credit arithmetic; returns -1 when the retirement underflows.
  function automatic int credit_next(input int cur, input int add, input int sub);
    if (cur + add < sub) return -1;
    return cur + add - sub;
  endfunction

endpackage

// File: rtl/pri_credit.sv
module pri_credit
  import pri_pkg::*;
#(
  parameter int MAX_DEPTH = 256,
  localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [1:0]       dec,
  input  logic [CNT_W-1:0] cfg_depth,
  output logic [CNT_W-1:0] count,
  output logic             room,
  output logic             underflow
);

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count_d;
  logic             under_ev;
  int               nxt;

  assign limit = CNT_W'(clamp_depth(int'(cfg_depth), MAX_DEPTH));
  assign room  = count < limit;

  always_comb begin
    nxt      = credit_next(int'(count), inc ? 1 : 0, int'(dec));
    under_ev = nxt < 0;
    count_d  = under_ev ? '0 : CNT_W'(nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      underflow <= 1'b0;
    end else begin
      count <= count_d;
      if (under_ev) underflow <= 1'b1;
    end
  end

endmodule

// File: rtl/pri_hold.sv
module pri_hold
  import pri_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CMD_W-1:0] cmd_in,
  input  logic [BUS_W-1:0] hi_in,
  output logic             valid,
  output logic [CMD_W-1:0] cmd_q,
  output logic [BUS_W-1:0] hi_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      cmd_q <= '0;
      hi_q  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      cmd_q <= cmd_in;
      hi_q  <= hi_in;
    end
  end

endmodule

// File: rtl/pri_encode.sv
module pri_encode
  import pri_pkg::*;
(
  input  logic [CMD_W-1:0]   cmd,
  input  logic [2*BUS_W-1:0] addr,
  input  logic [LEN_W-1:0]   len,
  input  logic               sticky,
  input  logic               hold_valid,
  input  logic [CMD_W-1:0]   hold_cmd,
  input  logic [BUS_W-1:0]   hold_hi,
  output beat_t              first,
  output beat_t              second,
  output logic               two_beats,
  output logic               load_hold
);

  logic [BUS_W-1:0] lo_word;
  logic [BUS_W-1:0] hi_word;
  logic             match;

  assign lo_word = {addr[BUS_W-1:LEN_W], len};
  assign hi_word = addr[2*BUS_W-1:BUS_W];
  assign match   = hold_valid && (hold_cmd == cmd) && (hold_hi == hi_word);

  always_comb begin
    first.kind  = CYC_FULL;
    first.cmd   = cmd;
    first.ad    = lo_word;
    second.kind = CYC_SHORT;
    second.cmd  = cmd;
    second.ad   = '0;
    two_beats   = 1'b0;
    load_hold   = 1'b0;
    if (!cmd_is_mem(cmd)) begin
      first.ad = '0;
    end else if (match) begin
      first.kind = CYC_SHORT;
    end else if (sticky) begin
      first.kind  = CYC_SETUP;
      first.ad    = hi_word;
      second.kind = CYC_SHORT;
      second.ad   = lo_word;
      two_beats   = 1'b1;
      load_hold   = 1'b1;
    end else if (|hi_word) begin
      first.kind  = CYC_DAC_LO;
      second.kind = CYC_DAC_HI;
      second.ad   = hi_word;
      two_beats   = 1'b1;
    end
  end

endmodule

// File: rtl/pipe_req_issuer.sv
module pipe_req_issuer
  import pri_pkg::*;
#(
  parameter int MAX_DEPTH = 256,
  localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cfg_depth,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CMD_W-1:0]   req_cmd,
  input  logic [2*BUS_W-1:0] req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               req_sticky,
  input  logic               req_wdata_ok,
  input  logic               rd_done,
  input  logic               wr_done,
  output logic               pipe_o,
  output logic [KIND_W-1:0]  kind_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic [BUS_W-1:0]   ad_o,
  output logic [CNT_W-1:0]   outstanding_o,
  output logic               underflow_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_SECOND, ST_FENCE} st_e;

  st_e              st;
  beat_t            beat_q;
  beat_t            second_q;
  logic             pipe_q;
  beat_t            plan_first;
  beat_t            plan_second;
  logic             plan_two;
  logic             plan_load;
  logic             hold_valid;
  logic [CMD_W-1:0] hold_cmd;
  logic [BUS_W-1:0] hold_hi;
  logic             room;
  logic [1:0]       retire_cnt;

  // Named internal events, also seen by the bound checker.
  logic accept;
  logic issue_counted;
  logic fence_taken;

  assign retire_cnt    = {1'b0, rd_done} + {1'b0, wr_done};
  assign req_ready     = (st == ST_IDLE) && cmd_known(req_cmd)
                         && (!cmd_is_write(req_cmd) || req_wdata_ok)
                         && (!cmd_takes_credit(req_cmd) || room);
  assign accept        = req_valid && req_ready;
  assign issue_counted = accept && cmd_takes_credit(req_cmd);
  assign fence_taken   = accept && (req_cmd == CMD_FENCE);

  pri_encode u_encode (
    .cmd        (req_cmd),
    .addr       (req_addr),
    .len        (req_len),
    .sticky     (req_sticky),
    .hold_valid (hold_valid),
    .hold_cmd   (hold_cmd),
    .hold_hi    (hold_hi),
    .first      (plan_first),
    .second     (plan_second),
    .two_beats  (plan_two),
    .load_hold  (plan_load)
  );

  pri_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept && plan_load),
    .cmd_in (req_cmd),
    .hi_in  (req_addr[2*BUS_W-1:BUS_W]),
    .valid  (hold_valid),
    .cmd_q  (hold_cmd),
    .hi_q   (hold_hi)
  );

  pri_credit #(.MAX_DEPTH(MAX_DEPTH)) u_credit (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (issue_counted),
    .dec       (retire_cnt),
    .cfg_depth (cfg_depth),
    .count     (outstanding_o),
    .room      (room),
    .underflow (underflow_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pipe_q   <= 1'b0;
      beat_q   <= '0;
      second_q <= '0;
    end else begin
      if (accept) begin
        pipe_q <= 1'b1;
        beat_q <= plan_first;
        if (plan_two) begin
          second_q <= plan_second;
          st       <= ST_SECOND;
        end else if (fence_taken) begin
          st <= ST_FENCE;
        end
      end else if (st == ST_SECOND) begin
        pipe_q <= 1'b1;
        beat_q <= second_q;
        st     <= ST_IDLE;
      end else begin
        pipe_q <= 1'b0;
        beat_q <= '0;
        if ((st == ST_FENCE) && (outstanding_o == '0)) st <= ST_IDLE;
      end
    end
  end

  assign pipe_o = pipe_q;
  assign kind_o = beat_q.kind;
  assign cmd_o  = beat_q.cmd;
  assign ad_o   = beat_q.ad;

endmodule

module pipe_req_issuer_chk
  import pri_pkg::*;
#(
  parameter int MAX_DEPTH = 256,
  localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  cfg_depth,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CMD_W-1:0]  req_cmd,
  input logic              req_wdata_ok,
  input logic              pipe_o,
  input logic [KIND_W-1:0] kind_o,
  input logic [CMD_W-1:0]  cmd_o,
  input logic [CNT_W-1:0]  outstanding_o,
  input logic              underflow_o,
  input logic              accept,
  input logic              fence_taken
);

  // R2
  accept_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pipe_o);

  // R3
  credit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && cmd_takes_credit(req_cmd))
      |-> (int'(outstanding_o) < clamp_depth(int'(cfg_depth), MAX_DEPTH)));

  // R5
  setup_then_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_o && kind_o == CYC_SETUP) |=> (pipe_o && kind_o == CYC_SHORT && $stable(cmd_o)));

  // R8
  dual_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_o && kind_o == CYC_DAC_LO) |=> (pipe_o && kind_o == CYC_DAC_HI && $stable(cmd_o)));

  // R9
  fence_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fence_taken |=> !req_ready);

  // R11
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (!cmd_known(req_cmd) || (cmd_is_write(req_cmd) && !req_wdata_ok))));

  // R12
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(outstanding_o) <= MAX_DEPTH);

  // R13
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> underflow_o);

endmodule

bind pipe_req_issuer pipe_req_issuer_chk #(.MAX_DEPTH(MAX_DEPTH)) u_chk (.*);

// File: tb/pipe_req_issuer_tb.sv
`timescale 1ns/1ps
module pipe_req_issuer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  cfg_depth = 9'd8;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cmd = 3'd0;
  logic [63:0] req_addr = '0;
  logic [2:0]  req_len = '0;
  logic        req_sticky = 1'b0;
  logic        req_wdata_ok = 1'b1;
  logic        rd_done = 1'b0;
  logic        wr_done = 1'b0;
  logic        pipe_o;
  logic [2:0]  kind_o;
  logic [2:0]  cmd_o;
  logic [31:0] ad_o;
  logic [8:0]  outstanding_o;
  logic        underflow_o;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pipe_req_issuer u_dut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bus word of a short/full/dual-low cycle, restated from the field layout.
  function automatic logic [31:0] low_word(input logic [63:0] a, input logic [2:0] l);
    return (a[31:0] & 32'hFFFF_FFF8) | {29'd0, l};
  endfunction

  task automatic beat(input string req, input logic [2:0] k, input logic [2:0] c, input logic [31:0] w);
    chk(req, "strobe", pipe_o, 1'b1);
    chk(req, "kind", kind_o, k);
    chk(req, "cmd", cmd_o, c);
    chk(req, "bus", ad_o, w);
  endtask

  task automatic idle_next(input string req);
    @(negedge clk);
    chk(req, "strobe idle", pipe_o, 1'b0);
  endtask

  // Present one request; it must be ready and is accepted at the next edge.
  task automatic send(input logic [2:0] c, input logic [63:0] a, input logic [2:0] l, input logic s);
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_addr = a; req_len = l; req_sticky = s; req_wdata_ok = 1;
    #0.5;
    chk("R3", "ready before send", req_ready, 1'b1);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic probe(input string req, input logic [2:0] c, input logic wok, input logic exp);
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_addr = 64'h80; req_len = 0; req_sticky = 0; req_wdata_ok = wok;
    #0.5;
    chk(req, "ready", req_ready, exp);
    req_valid = 0; req_wdata_ok = 1;
  endtask

  task automatic pulse(input logic rd, input logic wr);
    @(negedge clk);
    rd_done = rd; wr_done = wr;
    @(negedge clk);
    rd_done = 0; wr_done = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "strobe", pipe_o, 1'b0);
    chk("R1", "count", outstanding_o, 0);
    chk("R1", "underflow", underflow_o, 1'b0);
    probe("R1", 3'd0, 1'b1, 1'b1);
  endtask

  task automatic t_sticky();
    send(3'd2, 64'h5_0000_0100, 3'd1, 1'b1);
    exp_cnt = 1;
    beat("R5", 3'd1, 3'd2, 32'h5);
    chk("R5", "count", outstanding_o, exp_cnt);
    @(negedge clk);
    beat("R5", 3'd0, 3'd2, 32'h101);
    idle_next("R5");
  endtask

  task automatic t_full();
    send(3'd0, 64'h1000_0040, 3'd3, 1'b0);
    exp_cnt++;
    beat("R7", 3'd2, 3'd0, low_word(64'h1000_0040, 3'd3));
    chk("R7", "count", outstanding_o, exp_cnt);
    idle_next("R7");
  endtask

  task automatic t_short();
    // stored state is still write / upper word 5 after the full cycle (R7)
    send(3'd2, 64'h5_0000_0200, 3'd2, 1'b0);
    exp_cnt++;
    beat("R6", 3'd0, 3'd2, 32'h202);
    chk("R6", "count", outstanding_o, exp_cnt);
    idle_next("R7");
  endtask

  task automatic t_dac();
    send(3'd1, 64'hAB_0000_0010, 3'd0, 1'b0);
    exp_cnt++;
    beat("R8", 3'd3, 3'd1, 32'h10);
    chk("R8", "count", outstanding_o, exp_cnt);
    @(negedge clk);
    beat("R8", 3'd4, 3'd1, 32'hAB);
    idle_next("R8");
  endtask

  task automatic t_flush();
    send(3'd5, 64'h1234, 3'd5, 1'b0);
    exp_cnt++;
    beat("R10", 3'd2, 3'd5, 32'h0);
    chk("R10", "count", outstanding_o, exp_cnt);
  endtask

  task automatic t_gate();
    probe("R11", 3'd2, 1'b0, 1'b0);
    probe("R11", 3'd3, 1'b0, 1'b0);
    probe("R11", 3'd6, 1'b1, 1'b0);
    probe("R11", 3'd7, 1'b1, 1'b0);
    @(negedge clk);
    chk("R11", "no strobe", pipe_o, 1'b0);
    chk("R11", "count", outstanding_o, exp_cnt);
  endtask

  task automatic t_retire();
    pulse(1, 1); exp_cnt -= 2;
    chk("R12", "both retire", outstanding_o, exp_cnt);
    pulse(1, 0); exp_cnt -= 1;
    chk("R12", "read retire", outstanding_o, exp_cnt);
    pulse(0, 1); exp_cnt -= 1;
    chk("R12", "write retire", outstanding_o, exp_cnt);
    pulse(1, 0); exp_cnt -= 1;
    chk("R12", "drained", outstanding_o, exp_cnt);
  endtask

  task automatic t_fence();
    send(3'd0, 64'h40, 3'd0, 1'b0);
    send(3'd0, 64'h48, 3'd0, 1'b0);
    exp_cnt = 2;
    send(3'd4, 64'h999, 3'd0, 1'b0);
    beat("R9", 3'd2, 3'd4, 32'h0);
    chk("R9", "no credit", outstanding_o, exp_cnt);
    probe("R9", 3'd0, 1'b1, 1'b0);
    pulse(1, 0); exp_cnt = 1;
    probe("R9", 3'd0, 1'b1, 1'b0);
    pulse(1, 0); exp_cnt = 0;
    chk("R9", "count", outstanding_o, 0);
    probe("R9", 3'd0, 1'b1, 1'b1);
  endtask

  task automatic t_b2b();
    @(negedge clk);
    req_valid = 1; req_cmd = 3'd0; req_addr = 64'h80; req_len = 0; req_sticky = 0; req_wdata_ok = 1;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk("R2", "strobe", pipe_o, 1'b1);
      chk("R2", "count", outstanding_o, i);
    end
    req_valid = 0;
    exp_cnt = 3;
    idle_next("R2");
  endtask

  task automatic t_credit();
    cfg_depth = 9'd2;
    probe("R4", 3'd0, 1'b1, 1'b0);
    pulse(1, 0); exp_cnt = 2;
    probe("R4", 3'd0, 1'b1, 1'b0);
    pulse(1, 0); exp_cnt = 1;
    probe("R4", 3'd0, 1'b1, 1'b1);
    @(negedge clk);
    req_valid = 1; req_cmd = 3'd0; req_addr = 64'h80; req_sticky = 0;
    @(negedge clk);
    chk("R3", "count at limit", outstanding_o, 2);
    #0.5;
    chk("R3", "ready at limit", req_ready, 1'b0);
    req_valid = 0;
    pulse(1, 1); exp_cnt = 0;
    cfg_depth = 9'd0;
    @(negedge clk);
    req_valid = 1;
    @(negedge clk);
    chk("R3", "depth 0 count", outstanding_o, 1);
    #0.5;
    chk("R3", "depth 0 as 1", req_ready, 1'b0);
    req_valid = 0;
    cfg_depth = 9'h1FF;
    #0.5;
    req_valid = 1;
    #0.5;
    chk("R3", "depth above ceiling", req_ready, 1'b1);
    req_valid = 0;
    pulse(1, 0); exp_cnt = 0;
    cfg_depth = 9'd8;
  endtask

  task automatic t_underflow();
    pulse(1, 1);
    chk("R13", "saturate", outstanding_o, 0);
    chk("R13", "flag", underflow_o, 1'b1);
    @(negedge clk);
    chk("R13", "sticky", underflow_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_sticky();
    t_full();
    t_short();
    t_dac();
    t_flush();
    t_gate();
    t_retire();
    t_fence();
    t_b2b();
    t_credit();
    t_underflow();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-scope run: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule